// File: doc/BRIEF.md
# Lane Enable Mask Sequencer

This block holds the per-lane enable mask of a wide vector unit. Structured control flow uses it in place of a hardware reconvergence stack. A sequencer issues one control-flow operation per strobe. Each operation carries a per-lane condition vector and a saved-mask operand, which is normally a value the block itself returned earlier through its result output and which the sequencer kept in a scalar register.

The block runs the operation as a save, modify and restore on the one mask register. It also produces a result word for the sequencer to write back. Divergence works as follows:

- Entering a branch narrows the mask and hands back the lanes that were switched off.
- The alternate arm swaps the enabled set.
- The join merges the saved lanes back in.
- Loop exits accumulate per-lane break masks, which the loop operation then strips from the live mask.
- A kill operation drops lanes for good.

Two flags report whether any lane is still live, so the sequencer can jump past a region in which no lane would execute. Every operation takes one clock. The new mask, the result and the error pulse all appear after the next rising edge.

Top module: `lane_mask_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, mask_q is all ones, result_q is zero and bad_op is low.
- R2: Code 1 (branch entry): the new mask is old mask AND cond. The result is old mask AND NOT cond, which is the set of lanes the branch turned off.
- R3: Code 2 (alternate arm): the result is old mask OR saved. The new mask is that result XOR old mask, so only lanes that were off and are present in saved become live.
- R4: Code 3 (join): the new mask is old mask OR saved. The result register keeps its value.
- R5: Code 4 (break): the result is live mask OR saved, where saved is the break accumulator. The mask keeps its value.
- R6: Code 5 (conditional break): the result is (cond AND live mask) OR saved. The mask keeps its value.
- R7: Code 6 (break from alternate arm): the result is cond OR saved, with cond carrying a previously saved mask. The mask keeps its value.
- R8: Code 7 (loop back-edge): the new mask is old mask AND NOT saved, where saved is the accumulated break mask. The result register keeps its value.
- R9: Code 8 (kill): every lane whose cond bit is one (its operand is negative) is cleared from the mask. The result register keeps its value.
- R10: mask_zero is high exactly when mask_q is all zeros, and mask_live is its complement. Both follow mask_q in the same cycle.
- R11: An accepted strobe with code 0 or any code from 9 to 15 leaves mask_q and result_q unchanged and raises bad_op for exactly the following cycle.
- R12: With op_valid low, mask_q and result_q hold and bad_op is low in the following cycle, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code (see requirements) |
| cond | input | 64 | Per-lane condition or sign vector |
| saved | input | 64 | Saved-mask or accumulator operand |
| mask_q | output | 64 | Live lane enable mask |
| result_q | output | 64 | Word to be written back to a scalar register |
| mask_zero | output | 1 | No lane is live |
| mask_live | output | 1 | At least one lane is live |
| bad_op | output | 1 | One-cycle pulse after an undefined code |

## Verification
The bench goes after the cases where a slip stays hidden while the mask is full:

- A branch entry with an all-zero condition must empty the mask and raise mask_zero. A design that took cond instead of mask AND cond would go wrong once lanes were already off.
- An alternate arm entered under a partially killed mask must not wake the killed lanes. A plain inversion of the mask would revive them.
- A loop whose accumulated breaks cover every live lane must end with mask_zero high. A design that ORed in place of AND-NOT would never leave the loop.
- Undefined codes and idle strobes carry random operands. A design that decoded them loosely would disturb the mask or the result, or would miss the error pulse or stretch it over two cycles.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [3:0] {
    OP_BR_ENTER  = 4'd1,
    OP_BR_SWAP   = 4'd2,
    OP_BR_JOIN   = 4'd3,
    OP_BRK       = 4'd4,
    OP_BRK_COND  = 4'd5,
    OP_BRK_ALT   = 4'd6,
    OP_LOOP_BACK = 4'd7,
    OP_KILL      = 4'd8
  } lms_op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/lms_alu.sv
module lms_alu
  import lms_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_code,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] saved,
  input  logic [LANES-1:0] cur_mask,
  output logic [LANES-1:0] nxt_mask,
  output logic [LANES-1:0] nxt_res,
  output logic             mask_we,
  output logic             res_we,
  output logic             illegal_ev
);
  // Branch entry: lanes turned off by the branch.
  function automatic logic [LANES-1:0] enter_off(input logic [LANES-1:0] m,
                                                 input logic [LANES-1:0] c);
    logic [LANES-1:0] kept;
    kept = m & c;
    return m ^ kept;
  endfunction

  // Alternate arm: only lanes that were off come on.
  function automatic logic [LANES-1:0] swap_mask(input logic [LANES-1:0] m,
                                                 input logic [LANES-1:0] orsave);
    return orsave ^ m;
  endfunction

  always_comb begin
    nxt_mask   = cur_mask;
    nxt_res    = '0;
    mask_we    = 1'b0;
    res_we     = 1'b0;
    illegal_ev = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_BR_ENTER: begin
          nxt_mask = cur_mask & cond;
          nxt_res  = enter_off(cur_mask, cond);
          mask_we  = 1'b1;
          res_we   = 1'b1;
        end
        OP_BR_SWAP: begin
          nxt_res  = cur_mask | saved;
          nxt_mask = swap_mask(cur_mask, cur_mask | saved);
          mask_we  = 1'b1;
          res_we   = 1'b1;
        end
        OP_BR_JOIN: begin
          nxt_mask = cur_mask | saved;
          mask_we  = 1'b1;
        end
        OP_BRK: begin
          nxt_res = cur_mask | saved;
          res_we  = 1'b1;
        end
        OP_BRK_COND: begin
          nxt_res = (cond & cur_mask) | saved;
          res_we  = 1'b1;
        end
        OP_BRK_ALT: begin
          nxt_res = cond | saved;
          res_we  = 1'b1;
        end
        OP_LOOP_BACK: begin
          nxt_mask = cur_mask & ~saved;
          mask_we  = 1'b1;
        end
        OP_KILL: begin
          nxt_mask = cur_mask & ~cond;
          mask_we  = 1'b1;
        end
        default: illegal_ev = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lms_regs.sv
module lms_regs #(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             mask_we,
  input  logic             res_we,
  input  logic             illegal_ev,
  input  logic [LANES-1:0] nxt_mask,
  input  logic [LANES-1:0] nxt_res,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] result_q,
  output logic             bad_op
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      result_q <= '0;
      bad_op   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= nxt_mask;
      if (res_we) result_q <= nxt_res;
      bad_op <= illegal_ev;
    end
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(mask_q) && $stable(result_q) && !bad_op));

  // R11
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ev |=> (bad_op && $stable(mask_q) && $stable(result_q)));

  // R11
  bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> $past(op_valid));
endmodule

// File: rtl/lms_flags.sv
module lms_flags #(
  parameter int LANES = 64
) (
  input  logic [LANES-1:0] mask_q,
  output logic             mask_zero,
  output logic             mask_live
);
  logic any_lane;
  assign any_lane  = |mask_q;
  assign mask_live = any_lane;
  assign mask_zero = ~any_lane;
endmodule

// File: rtl/lane_mask_seq.sv
module lane_mask_seq
  import lms_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] saved,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] result_q,
  output logic             mask_zero,
  output logic             mask_live,
  output logic             bad_op
);
  logic [LANES-1:0] nxt_mask;
  logic [LANES-1:0] nxt_res;
  logic             mask_we;
  logic             res_we;
  logic             illegal_ev;

  lms_alu #(.LANES(LANES)) alu_i (
    .op_valid(op_valid), .op_code(op_code), .cond(cond), .saved(saved),
    .cur_mask(mask_q), .nxt_mask(nxt_mask), .nxt_res(nxt_res),
    .mask_we(mask_we), .res_we(res_we), .illegal_ev(illegal_ev)
  );

  lms_regs #(.LANES(LANES)) regs_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mask_we(mask_we),
    .res_we(res_we), .illegal_ev(illegal_ev), .nxt_mask(nxt_mask),
    .nxt_res(nxt_res), .mask_q(mask_q), .result_q(result_q), .bad_op(bad_op)
  );

  lms_flags #(.LANES(LANES)) flags_i (
    .mask_q(mask_q), .mask_zero(mask_zero), .mask_live(mask_live)
  );

  logic op_enter, op_swap, op_join, op_loop, op_kill;
  assign op_enter = op_valid && (op_code == OP_BR_ENTER);
  assign op_swap  = op_valid && (op_code == OP_BR_SWAP);
  assign op_join  = op_valid && (op_code == OP_BR_JOIN);
  assign op_loop  = op_valid && (op_code == OP_LOOP_BACK);
  assign op_kill  = op_valid && (op_code == OP_KILL);

  // R2
  enter_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_enter |=> ((mask_q & ~$past(mask_q)) == '0) && ((mask_q & result_q) == '0));

  // R3
  swap_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_swap |=> ((mask_q & $past(mask_q)) == '0));

  // R4
  join_widens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_join |=> ((mask_q & $past(mask_q)) == $past(mask_q)) && $stable(result_q));

  // R8
  loop_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_loop |=> ((mask_q & $past(saved)) == '0) && ((mask_q & ~$past(mask_q)) == '0));

  // R9
  kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_kill |=> ((mask_q & $past(cond)) == '0) && $stable(result_q));

  // R10
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_zero == (mask_q == '0));
endmodule

// File: tb/lane_mask_seq_tb.sv
`timescale 1ns/1ps
module lane_mask_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [63:0] cond = '0;
  logic [63:0] saved = '0;
  logic [63:0] mask_q, result_q;
  logic        mask_zero, mask_live, bad_op;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] ref_mask = '1;
  logic [63:0] ref_res = '0;
  bit          ref_bad = 1'b0;

  always #4 clk = ~clk;

  lane_mask_seq dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cond(cond), .saved(saved), .mask_q(mask_q), .result_q(result_q),
    .mask_zero(mask_zero), .mask_live(mask_live), .bad_op(bad_op)
  );

  function automatic string tag_of(input bit v, input logic [3:0] c);
    if (!v) return "R12";
    case (c)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check64(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check64(tag, "mask", mask_q, ref_mask);
    check64(tag, "result", result_q, ref_res);
    check64(tag, "bad_op", {63'd0, bad_op}, {63'd0, ref_bad});
    check64("R10", "mask_zero", {63'd0, mask_zero}, {63'd0, ref_mask == 64'd0});
    check64("R10", "mask_live", {63'd0, mask_live}, {63'd0, ref_mask != 64'd0});
  endtask

  // Lane-by-lane behavioural model of one clock.
  task automatic model_step(input bit v, input logic [3:0] c,
                            input logic [63:0] cv, input logic [63:0] sv);
    logic [63:0] nm, nr;
    nm = ref_mask;
    nr = ref_res;
    ref_bad = 1'b0;
    if (v) begin
      if (c == 4'd0 || c > 4'd8) ref_bad = 1'b1;
      for (int i = 0; i < 64; i++) begin
        bit m, cb, s;
        m = ref_mask[i]; cb = cv[i]; s = sv[i];
        case (c)
          4'd1: begin nm[i] = m && cb; nr[i] = m && !cb; end
          4'd2: begin nr[i] = m || s; nm[i] = !m && s; end
          4'd3: nm[i] = m || s;
          4'd4: nr[i] = m || s;
          4'd5: nr[i] = (cb && m) || s;
          4'd6: nr[i] = cb || s;
          4'd7: nm[i] = m && !s;
          4'd8: if (cb) nm[i] = 1'b0;
          default: ;
        endcase
      end
    end
    ref_mask = nm;
    ref_res = nr;
  endtask

  task automatic do_op(input bit v, input logic [3:0] c,
                       input logic [63:0] cv, input logic [63:0] sv);
    op_valid = v; op_code = c; cond = cv; saved = sv;
    model_step(v, c, cv, sv);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag_of(v, c));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] s_outer, s_inner, acc;
    repeat (3) @(negedge clk);
    // R1: reset values while held
    compare_all("R1");
    rst_n = 1'b1;
    // R12: idle with junk operands, R1 on first cycle after reset
    do_op(1'b0, 4'd2, rnd64(), rnd64());
    for (int k = 0; k < 6; k++) do_op(1'b0, 4'($urandom()), rnd64(), rnd64());

    // R2 R3 R4: nested divergence with returned values as saved operands
    do_op(1'b1, 4'd1, 64'h00FF_00FF_F0F0_1234, rnd64());
    s_outer = ref_res;
    do_op(1'b1, 4'd1, 64'h0F0F_0F0F_0F0F_0F0F, '0);
    s_inner = ref_res;
    do_op(1'b1, 4'd2, rnd64(), s_inner);
    s_inner = ref_res;
    do_op(1'b1, 4'd3, '0, s_inner);
    do_op(1'b1, 4'd2, '0, s_outer);
    s_outer = ref_res;
    do_op(1'b1, 4'd3, '0, s_outer);

    // R2 R10: empty condition drains all lanes, then recovery
    do_op(1'b1, 4'd1, '0, '0);
    s_outer = ref_res;
    do_op(1'b1, 4'd2, '0, s_outer);
    do_op(1'b1, 4'd3, '0, ref_res);

    // R9 then R3: killed lanes must stay off through an alternate arm
    do_op(1'b1, 4'd8, 64'hFFFF_0000_0000_0001, '0);
    do_op(1'b1, 4'd1, 64'h0000_FFFF_0000_FFFF, '0);
    s_outer = ref_res;
    do_op(1'b1, 4'd2, '0, s_outer);
    do_op(1'b1, 4'd3, '0, ref_res);

    // R5 R6 R7 R8: break accumulation and loop exit
    acc = '0;
    do_op(1'b1, 4'd5, 64'h0000_0000_FFFF_0000, acc);  acc = ref_res;
    do_op(1'b1, 4'd7, '0, acc);
    do_op(1'b1, 4'd6, 64'h0000_0F00_0000_0000, acc);  acc = ref_res;
    do_op(1'b1, 4'd7, '0, acc);
    do_op(1'b1, 4'd4, '0, acc);                        acc = ref_res;
    do_op(1'b1, 4'd7, '0, acc);                        // R8 all lanes broken
    do_op(1'b1, 4'd3, '0, 64'hFFFF_FFFF_FFFF_FFFF);

    // R11: undefined codes with random operands
    do_op(1'b1, 4'd0, rnd64(), rnd64());
    do_op(1'b1, 4'd9, rnd64(), rnd64());
    do_op(1'b1, 4'd15, rnd64(), rnd64());
    do_op(1'b0, 4'd15, rnd64(), rnd64());
    do_op(1'b1, 4'd12, rnd64(), rnd64());
    do_op(1'b1, 4'd11, rnd64(), rnd64());

    // Random mix of every code, idle cycles and lane patterns
    for (int k = 0; k < 600; k++) begin
      logic [63:0] cv, sv;
      cv = rnd64();
      sv = ($urandom() % 3 == 0) ? ref_res : rnd64();
      if ($urandom() % 8 == 0) cv = '0;
      if ($urandom() % 8 == 0) sv = '1;
      if (ref_mask == '0 && $urandom() % 2 == 0) do_op(1'b1, 4'd3, '0, rnd64());
      else do_op($urandom() % 6 != 0, 4'($urandom()), cv, sv);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule